// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block turns a 16-bit half-precision floating-point operand into a 32-bit single-precision value in one combinational pass, with no clock and no storage. Every half value fits in single precision with room to spare, so the widening is always exact and never rounds. A format select picks one of two readings of the half operand. In the standard reading, the all-ones exponent encodes infinity and NaN. In the alternative reading, that exponent is an ordinary finite exponent, which doubles the top of the range.

The operand is sorted into one of five classes: CLS_ZERO, CLS_SUBNORM, CLS_NORMAL, CLS_INF and CLS_NAN. A `unique case` on the class builds the result. The classes are selected by input value only. There are no transitions between them and no state is kept. A subnormal half has no leading one in its fraction. A leading-zero counter finds the first set fraction bit, and the fraction is shifted past it, so the result is a normal single. A NaN input leaves as a quiet NaN. The `invalid` output reports when the incoming NaN was signalling.

Top module: `h2s_convert`

## Requirements
- R1: An input whose exponent field and fraction are both zero produces a single zero with the same sign: out[30:0] = 0.
- R2: For a half exponent field e in 1..30, the single exponent is e + 112 and the 10-bit half fraction fills out[22:13], with out[12:0] = 0.
- R3: For exponent field 0 with a nonzero fraction f, let z be the number of leading zeros of f within 10 bits. The single exponent is 112 - z. The fraction is f shifted left by z+1, with bits above bit 9 dropped, and placed in out[22:13]. A nonzero input never gives a single exponent of 0.
- R4: With alt_fmt = 0, exponent field 31 and a zero fraction give out = {sign, 8'hFF, 23'h0}.
- R5: With alt_fmt = 0, exponent field 31 and a nonzero fraction give a quiet NaN {sign, 8'hFF, 1'b1, in[8:0], 13'h0}. Every NaN on the output has out[22] = 1.
- R6: `invalid` is 1 exactly when alt_fmt = 0, the exponent field is 31, the fraction is nonzero and in[9] (the quiet bit) is 0.
- R7: With alt_fmt = 1, exponent field 31 is finite. It gives single exponent 143 and copies the fraction as in R2. The output exponent is never 8'hFF in this mode.
- R8: With alt_fmt = 1, `invalid` is always 0.
- R9: out[31] always equals in[15].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_half | input | 16 | Half-precision operand: sign bit 15, exponent 14:10, fraction 9:0 |
| alt_fmt | input | 1 | 0 = standard half with infinity/NaN, 1 = alternative half where the top exponent is finite |
| out_single | output | 32 | Single-precision result: sign bit 31, exponent 30:23, fraction 22:0 |
| invalid | output | 1 | Set when a signalling NaN was quieted |

## Verification
The assertions assume that `in_half` and `alt_fmt` hold known values, because they are evaluated whenever the combinational logic settles and cannot be switched off by a reset. The bench gives both inputs zero values at declaration. It changes them only just after a clock edge and reads the outputs at the next falling edge, so no undriven value ever reaches the checked logic. A table of hand-worked vectors covers each class and both format readings. After that, a sweep compares all 65,536 operands under both format readings against a reference model in the bench.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

    localparam int HALF_EXP_W  = 5;
    localparam int HALF_FRAC_W = 10;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBNORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN
    } half_class_e;

endpackage

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
    parameter int W  = 10,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    logic seen;

    // Count zeros from the top until the first set bit.
    always_comb begin
        cnt  = '0;
        seen = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (vec[i]) begin
                    seen = 1'b1;
                end else begin
                    cnt = cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/h2s_classify.sv
module h2s_classify
    import h2s_pkg::*;
#(
    parameter int HE = HALF_EXP_W,
    parameter int HF = HALF_FRAC_W,
    localparam int HW = 1 + HE + HF
) (
    input  logic [HW-1:0]  op,
    input  logic           alt_fmt,
    output half_class_e    cls,
    output logic           sgn,
    output logic [HE-1:0]  ex,
    output logic [HF-1:0]  fr
);

    logic ex_zero;
    logic ex_special;
    logic fr_nz;

    assign sgn = op[HW-1];
    assign ex  = op[HW-2:HF];
    assign fr  = op[HF-1:0];

    always_comb begin
        ex_zero    = (ex == '0);
        // All-ones exponent is special only in the standard reading.
        ex_special = (&ex) && !alt_fmt;
        fr_nz      = |fr;
        unique case ({ex_zero, ex_special})
            2'b10:   cls = fr_nz ? CLS_SUBNORM : CLS_ZERO;
            2'b01:   cls = fr_nz ? CLS_NAN     : CLS_INF;
            default: cls = CLS_NORMAL;
        endcase
    end

endmodule

// File: rtl/h2s_pack.sv
module h2s_pack
    import h2s_pkg::*;
#(
    parameter int HE = HALF_EXP_W,
    parameter int HF = HALF_FRAC_W,
    parameter int SE = SGL_EXP_W,
    parameter int SF = SGL_FRAC_W,
    localparam int LZW      = $clog2(HF + 1),
    localparam int PAD      = SF - HF,
    localparam int BIAS_ADJ = ((2 ** (SE - 1)) - 1) - ((2 ** (HE - 1)) - 1),
    localparam int SW       = 1 + SE + SF
) (
    input  half_class_e    cls,
    input  logic           sgn,
    input  logic [HE-1:0]  ex,
    input  logic [HF-1:0]  fr,
    input  logic [LZW-1:0] lz,
    output logic [SW-1:0]  result,
    output logic           invalid
);

    logic [SE-1:0] res_exp;
    logic [SF-1:0] res_frac;
    logic [HF-1:0] sub_sh;

    always_comb begin
        res_exp  = '0;
        res_frac = '0;
        invalid  = 1'b0;
        // Pushing the leading one out of the field leaves the stored fraction.
        sub_sh   = fr << (lz + LZW'(1));
        unique case (cls)
            CLS_ZERO: begin
                res_exp  = '0;
                res_frac = '0;
            end
            CLS_SUBNORM: begin
                res_exp  = SE'(BIAS_ADJ) - SE'(lz);
                res_frac = {sub_sh, {PAD{1'b0}}};
            end
            CLS_NORMAL: begin
                res_exp  = SE'(ex) + SE'(BIAS_ADJ);
                res_frac = {fr, {PAD{1'b0}}};
            end
            CLS_INF: begin
                res_exp  = '1;
                res_frac = '0;
            end
            CLS_NAN: begin
                res_exp  = '1;
                res_frac = {1'b1, fr[HF-2:0], {PAD{1'b0}}};
                invalid  = ~fr[HF-1];
            end
            default: begin
                res_exp  = '0;
                res_frac = '0;
            end
        endcase
        result = {sgn, res_exp, res_frac};
    end

    // A quieted NaN always carries its quiet bit.
    always_comb begin
        if (cls == CLS_NAN) begin
            assert_nan_quiet_R5: assert (result[SF-1] && (&result[SW-2:SF]));
        end
        if (cls == CLS_SUBNORM) begin
            assert_subnorm_normal_R3: assert (result[SW-2:SF] != '0);
        end
    end

endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
    import h2s_pkg::*;
#(
    parameter int HE = HALF_EXP_W,
    parameter int HF = HALF_FRAC_W,
    parameter int SE = SGL_EXP_W,
    parameter int SF = SGL_FRAC_W,
    localparam int HW  = 1 + HE + HF,
    localparam int SW  = 1 + SE + SF,
    localparam int LZW = $clog2(HF + 1)
) (
    input  logic [HW-1:0] in_half,
    input  logic          alt_fmt,
    output logic [SW-1:0] out_single,
    output logic          invalid
);

    half_class_e    cls;
    logic           sgn;
    logic [HE-1:0]  ex;
    logic [HF-1:0]  fr;
    logic [LZW-1:0] lz;

    h2s_classify #(.HE(HE), .HF(HF)) u_classify (
        .op      (in_half),
        .alt_fmt (alt_fmt),
        .cls     (cls),
        .sgn     (sgn),
        .ex      (ex),
        .fr      (fr)
    );

    h2s_lzc #(.W(HF)) u_lzc (
        .vec (fr),
        .cnt (lz)
    );

    h2s_pack #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) u_pack (
        .cls     (cls),
        .sgn     (sgn),
        .ex      (ex),
        .fr      (fr),
        .lz      (lz),
        .result  (out_single),
        .invalid (invalid)
    );

    // Port-level relations between operand and result.
    always_comb begin
        assert_sign_copy_R9: assert (out_single[SW-1] == in_half[HW-1]);
        if (in_half[HW-2:0] == '0) begin
            assert_zero_out_R1: assert (out_single[SW-2:0] == '0);
        end
        if (out_single[SW-2:SF] == '0) begin
            assert_no_sub_out_R3: assert (out_single[SF-1:0] == '0);
        end
        if (invalid) begin
            assert_invalid_src_R6: assert (!alt_fmt && (&in_half[HW-2:HF]) && !in_half[HF-1]
                                           && (in_half[HF-1:0] != '0));
        end
        if (alt_fmt) begin
            assert_alt_finite_R7: assert (out_single[SW-2:SF] != '1);
            assert_alt_noinv_R8: assert (!invalid);
        end
        if ((&out_single[SW-2:SF]) && (out_single[SF-1:0] != '0)) begin
            assert_nan_quiet_out_R5: assert (out_single[SF-1]);
        end
    end

endmodule

// File: tb/tb_h2s_convert.sv
`timescale 1ns/1ps
module tb_h2s_convert;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_half = 16'h0000;
    logic        alt_fmt = 1'b0;
    logic [31:0] out_single;
    logic        invalid;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int WD_LIMIT = 190000;
    localparam int NVEC = 17;

    always #4 clk = ~clk;  // 125 MHz

    h2s_convert dut (
        .in_half    (in_half),
        .alt_fmt    (alt_fmt),
        .out_single (out_single),
        .invalid    (invalid)
    );

    // {alt, in[15:0], invalid, out[31:0]}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 1'b0, 32'h00000000},  // R1 +0
        {1'b0, 16'h8000, 1'b0, 32'h80000000},  // R1 -0
        {1'b0, 16'h3C00, 1'b0, 32'h3F800000},  // R2 1.0
        {1'b0, 16'hC000, 1'b0, 32'hC0000000},  // R2 -2.0
        {1'b0, 16'h7BFF, 1'b0, 32'h477FE000},  // R2 largest finite
        {1'b0, 16'h0001, 1'b0, 32'h33800000},  // R3 smallest subnormal
        {1'b0, 16'h03FF, 1'b0, 32'h387FC000},  // R3 largest subnormal
        {1'b0, 16'h8200, 1'b0, 32'hB8000000},  // R3 negative subnormal
        {1'b0, 16'h7C00, 1'b0, 32'h7F800000},  // R4 +inf
        {1'b0, 16'hFC00, 1'b0, 32'hFF800000},  // R4 -inf
        {1'b0, 16'h7E00, 1'b0, 32'h7FC00000},  // R5 quiet NaN
        {1'b0, 16'h7C01, 1'b1, 32'h7FC02000},  // R6 signalling NaN
        {1'b0, 16'hFD55, 1'b1, 32'hFFEAA000},  // R6 negative signalling NaN
        {1'b1, 16'h7C00, 1'b0, 32'h47800000},  // R7 top exponent finite
        {1'b1, 16'h7FFF, 1'b0, 32'h47FFE000},  // R7 alt largest
        {1'b1, 16'hFC01, 1'b0, 32'hC7802000},  // R8 would be sNaN
        {1'b1, 16'h0001, 1'b0, 32'h33800000}   // R3 alt subnormal
    };

    function automatic logic [32:0] ref_model(input logic alt, input logic [15:0] h);
        logic [4:0]  e;
        logic [9:0]  f;
        logic [7:0]  oe;
        logic [22:0] of;
        logic [10:0] m;
        logic        inv;
        int          k;
        e = h[14:10];
        f = h[9:0];
        oe = 8'h00;
        of = 23'h0;
        inv = 1'b0;
        if (e == 5'd0) begin
            if (f != 10'd0) begin
                m = {1'b0, f};
                k = 113;
                while (m[10] == 1'b0) begin
                    m = m << 1;
                    k = k - 1;
                end
                oe = k[7:0];
                of = {m[9:0], 13'h0};
            end
        end else if (e == 5'd31 && !alt) begin
            oe = 8'hFF;
            if (f != 10'd0) begin
                of = {1'b1, f[8:0], 13'h0};
                inv = ~f[9];
            end
        end else begin
            oe = 8'(e) + 8'd112;
            of = {f, 13'h0};
        end
        return {inv, h[15], oe, of};
    endfunction

    function automatic string tag_of(input logic alt, input logic [15:0] h);
        if (h[14:0] == 15'd0) return "R1";
        if (h[14:10] == 5'd0) return "R3";
        if (h[14:10] == 5'd31 && alt) return "R7/R8";
        if (h[14:10] == 5'd31 && h[9:0] == 10'd0) return "R4";
        if (h[14:10] == 5'd31) return "R5/R6";
        return "R2";
    endfunction

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic check(input logic alt, input logic [15:0] h,
                         input logic [32:0] exp_v, input string tag);
        @(posedge clk);
        #1;
        alt_fmt = alt;
        in_half = h;
        @(negedge clk);
        n_cmp++;
        if ({invalid, out_single} !== exp_v) begin
            n_bad++;
            $display("FAIL %s alt=%0b in=%h: got out=%h inv=%b, expected out=%h inv=%b",
                     tag, alt, h, out_single, invalid, exp_v[31:0], exp_v[32]);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT && !done) begin
            n_bad++;
            $display("FAIL watchdog: got cycle=%0d, expected completion before %0d", cyc, WD_LIMIT);
            report();
        end
    end

    initial begin
        // Reset phase: zero operand must give +0 (R1).
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if ({invalid, out_single} !== 33'h0) begin
            n_bad++;
            $display("FAIL R1 reset: got out=%h inv=%b, expected out=00000000 inv=0",
                     out_single, invalid);
        end
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            check(VEC[i][49], VEC[i][48:33], VEC[i][32:0], tag_of(VEC[i][49], VEC[i][48:33]));
        end

        // R9 sign copy on values of each class.
        check(1'b0, 16'hBC00, 33'h0BF800000, "R9");
        check(1'b1, 16'hFFFF, 33'h0C7FFE000, "R9");
        check(1'b0, 16'h83FF, 33'h0B87FC000, "R9");

        // Full sweep in both readings.
        for (int a = 0; a < 2; a++) begin
            for (int v = 0; v < 65536; v++) begin
                check(a[0], v[15:0], ref_model(a[0], v[15:0]), tag_of(a[0], v[15:0]));
            end
        end

        report();
    end

endmodule